// File: doc/BRIEF.md
# DRAM Controller Event Counter Unit

This unit watches a DRAM controller's activity and counts it for software. It holds a group of programmable counters and two fixed-purpose counters. Each programmable counter has its own selector, which picks one line from a vector of single-cycle event pulses. Those pulses come from the controller's PHY side, from its interconnect side, or from its internal logic. One fixed counter counts DRAM read strobes and the other counts DRAM write strobes. All counters are 48 bits wide by default.

Software configures and reads the unit through a plain register port. It can set the selectors, turn counting on and off with a single global enable, and restart the whole programmable group at once. A single programmable counter cannot be restarted on its own. The two counter kinds treat overflow differently. The fixed counters roll over to zero and keep counting. The programmable counters stop at full scale. There is no interrupt, so software finds an overflow only by reading the counts. A count wider than the data bus is read in two parts, a low word and then a high word. Reading the low word captures the high part, so the two reads belong to the same instant.

Top module: `dram_perf_counters`

## Requirements
- R1: There are NUM_PROG programmable counters. Counter i has a selector at address 0x10+i. A selector value k from 1 to NUM_EVT makes the counter add one in every enabled cycle in which `evt_i[k-1]` is high.
- R2: A selector value of 0 picks no event, and that counter keeps its value.
- R3: The fixed read counter adds one in every enabled cycle in which `rd_strobe_i` is high. The fixed write counter does the same for `wr_strobe_i`.
- R4: A fixed counter at the all-ones value goes to zero on its next counted strobe and then keeps counting.
- R5: A programmable counter that reaches the all-ones value stays there until a group restart.
- R6: Bit 0 of the control register (address 0x00) is the global enable. While it is 0, no counter changes, except through a restart.
- R7: Writing the control register with bit 1 set clears every programmable counter in that same clock edge. An event present in that cycle is not counted. The fixed counters are not touched by the restart.
- R8: A read with `reg_rd_en` high presents its data on `reg_rdata` one cycle later. The addresses are:
  - control register at 0x00, with the enable in bit 0;
  - high-word snapshot at 0x01;
  - selectors at 0x10+i;
  - counter low words at 0x20+j, where j = 0..NUM_PROG-1 are the programmable counters, j = NUM_PROG is the read counter and j = NUM_PROG+1 is the write counter.
- R9: A counter's low word holds count bits [LO_W-1:0]. Reading a low word also captures bits [CNT_W-1:LO_W] of that counter into the snapshot at 0x01. The snapshot changes only when a low word is read.
- R10: After reset, every counter, every selector, the enable and the snapshot are zero.
- R11: No counter changes by more than one per clock cycle, except when a restart clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_EVT | Single-cycle event pulses |
| rd_strobe_i | input | 1 | One DRAM read per high cycle |
| wr_strobe_i | input | 1 | One DRAM write per high cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd_en` |

## Verification
Some properties are checked on every cycle by the assertions:
- every counter moves by at most one;
- a saturated programmable counter stays put, and a fixed counter rolls from all ones to zero;
- a restart leaves the programmable group at zero;
- nothing moves while disabled, and a counter with selector 0 holds its value;
- the snapshot changes only on a low-word read.

The bench scenarios show the rest. Each selector connects to the intended event line. The exact counts match under several pulse patterns. An event that arrives in the same cycle as a restart is dropped. A low/high pair read while the counter keeps running returns the high part captured at the earlier instant. The bench uses a narrow counter, so saturation and rollover are reached within a short run.

// File: rtl/dpc_pkg.sv
// Package: dpc_pkg
// Holds the register map and control bit positions shared by the
// counter unit and its checker. Assumes an 8-bit address and a 32-bit data bus.
package dpc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_HI   = 8'h01;
    localparam logic [ADDR_W-1:0] SEL_BASE  = 8'h10;
    localparam logic [ADDR_W-1:0] CNT_BASE  = 8'h20;
    localparam int CTRL_EN_BIT      = 0;
    localparam int CTRL_RESTART_BIT = 1;
endpackage

// File: rtl/dpc_prog_counter.sv
// Module: dpc_prog_counter
// Saturating event counter. Its selector picks one line of the event vector,
// where value k picks line k-1 and value 0 picks nothing. The counter stops
// at all ones. A group restart clears it and wins over an event in the same cycle.
// Assumes the event pulses are already synchronous to clk.
module dpc_prog_counter #(
    parameter int CNT_W   = 48,
    parameter int NUM_EVT = 15,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               count_en,
    input  logic               restart,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] events,
    output logic [CNT_W-1:0]   cnt
);
    logic hit;
    logic at_max;

    // Decode the selector into the chosen event line.
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (sel == SEL_W'(k + 1)) hit = events[k];
        end
    end

    assign at_max = &cnt;

    // Count the chosen event, stopping at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt <= '0;
        else if (restart)                     cnt <= '0;
        else if (count_en && hit && !at_max)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dpc_fixed_counter.sv
// Module: dpc_fixed_counter
// Rolling counter for one dedicated strobe. Past all ones it returns to zero
// and keeps counting. The group restart does not reach it.
// Assumes the strobe is high for at most one transaction per cycle.
module dpc_fixed_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             strobe,
    output logic [CNT_W-1:0] cnt
);
    // Add one per enabled strobe, with natural modulo rollover.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (count_en && strobe)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dpc_regs.sv
// Module: dpc_regs
// Register front end. It holds the enable bit and the selectors, and it
// decodes the restart command. It returns read data one cycle after the
// read strobe. A low-word read captures the upper count bits into the snapshot.
// Assumes CNT_W-LO_W <= 32, LO_W <= 32 and NUM_PROG+2 <= 16.
module dpc_regs
    import dpc_pkg::*;
#(
    parameter int NUM_PROG = 8,
    parameter int NUM_CNT  = 10,
    parameter int CNT_W    = 48,
    parameter int LO_W     = 32,
    parameter int SEL_W    = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic                                rd_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [DATA_W-1:0]                   rdata,
    output logic                                count_en,
    output logic                                restart,
    output logic [NUM_PROG-1:0][SEL_W-1:0]      sel,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]       counts,
    output logic [DATA_W-1:0]                   hi_snap
);
    logic [DATA_W-1:0] rd_value;
    logic [DATA_W-1:0] hi_value;
    logic              cnt_hit;
    logic [63:0]       wide;

    // Decode the restart command from a control write.
    assign restart = wr_en && (addr == ADDR_CTRL) && wdata[CTRL_RESTART_BIT];

    // Hold the enable and selector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_en <= 1'b0;
            sel      <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_CTRL) count_en <= wdata[CTRL_EN_BIT];
            for (int i = 0; i < NUM_PROG; i++) begin
                if (addr == ADDR_W'(SEL_BASE + i)) sel[i] <= wdata[SEL_W-1:0];
            end
        end
    end

    // Choose the read value and, for counters, the upper part to capture.
    always_comb begin
        rd_value = '0;
        hi_value = '0;
        cnt_hit  = 1'b0;
        wide     = '0;
        if (addr == ADDR_CTRL) rd_value = DATA_W'(count_en);
        if (addr == ADDR_HI)   rd_value = hi_snap;
        for (int i = 0; i < NUM_PROG; i++) begin
            if (addr == ADDR_W'(SEL_BASE + i)) rd_value = DATA_W'(sel[i]);
        end
        for (int j = 0; j < NUM_CNT; j++) begin
            if (addr == ADDR_W'(CNT_BASE + j)) begin
                wide     = 64'(counts[j]);
                rd_value = DATA_W'(wide[LO_W-1:0]);
                hi_value = DATA_W'(wide >> LO_W);
                cnt_hit  = 1'b1;
            end
        end
    end

    // Register the read data and capture the snapshot on a low-word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata   <= '0;
            hi_snap <= '0;
        end else if (rd_en) begin
            rdata <= rd_value;
            if (cnt_hit) hi_snap <= hi_value;
        end
    end
endmodule

// File: rtl/dram_perf_counters.sv
// Module: dram_perf_counters
// Top of the DRAM controller event counter unit. It has NUM_PROG saturating
// programmable counters and two rolling fixed counters (reads, writes) behind
// a simple register port. It has no interrupt output.
// Assumes every input is synchronous to clk.
module dram_perf_counters
    import dpc_pkg::*;
#(
    parameter int NUM_PROG = 8,
    parameter int NUM_EVT  = 15,
    parameter int CNT_W    = 48,
    parameter int LO_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               rd_strobe_i,
    input  logic               wr_strobe_i,
    input  logic               reg_wr_en,
    input  logic               reg_rd_en,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata
);
    localparam int SEL_W   = $clog2(NUM_EVT + 1);
    localparam int NUM_FIX = 2;
    localparam int NUM_CNT = NUM_PROG + NUM_FIX;

    logic                           count_en;
    logic                           restart;
    logic [NUM_PROG-1:0][SEL_W-1:0] sel;
    logic [NUM_CNT-1:0][CNT_W-1:0]  counts;
    logic [DATA_W-1:0]              hi_snap;
    logic [NUM_FIX-1:0]             fix_strobe;

    assign fix_strobe = {wr_strobe_i, rd_strobe_i};

    dpc_regs #(
        .NUM_PROG(NUM_PROG), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W),
        .LO_W(LO_W), .SEL_W(SEL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .count_en(count_en), .restart(restart), .sel(sel),
        .counts(counts), .hi_snap(hi_snap)
    );

    for (genvar i = 0; i < NUM_PROG; i++) begin : g_prog
        dpc_prog_counter #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .count_en(count_en), .restart(restart),
            .sel(sel[i]), .events(evt_i), .cnt(counts[i])
        );
    end

    for (genvar f = 0; f < NUM_FIX; f++) begin : g_fixed
        dpc_fixed_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .count_en(count_en),
            .strobe(fix_strobe[f]), .cnt(counts[NUM_PROG + f])
        );
    end
endmodule

// File: rtl/dpc_checker.sv
// Module: dpc_checker
// Clocked properties for dram_perf_counters, attached by bind. The properties
// check step size, saturation, rollover, restart, enable gating, selector
// zero and snapshot stability.
module dpc_checker
    import dpc_pkg::*;
#(
    parameter int NUM_PROG = 8,
    parameter int NUM_CNT  = 10,
    parameter int CNT_W    = 48,
    parameter int SEL_W    = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           count_en,
    input logic                           restart,
    input logic                           rd_en,
    input logic [ADDR_W-1:0]              addr,
    input logic [NUM_PROG-1:0][SEL_W-1:0] sel,
    input logic [NUM_CNT-1:0][CNT_W-1:0]  counts,
    input logic [1:0]                     fix_strobe,
    input logic [DATA_W-1:0]              hi_snap
);
    logic cnt_read;
    assign cnt_read = rd_en && (addr >= CNT_BASE) && (addr < ADDR_W'(CNT_BASE + NUM_CNT));

    // R6: all counts hold while disabled and no restart is issued
    p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !restart) |=> $stable(counts));

    // R9: snapshot moves only on a counter low-word read
    p_hi_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_read |=> $stable(hi_snap));

    for (genvar i = 0; i < NUM_PROG; i++) begin : g_p
        // R11: programmable step of zero or one
        p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !restart |=> (CNT_W'(counts[i] - $past(counts[i])) <= CNT_W'(1)));
        // R5: saturated value stays
        p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ((&counts[i]) && !restart) |=> (&counts[i]));
        // R7: restart leaves zero
        p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> (counts[i] == '0));
        // R2: selector zero holds
        p_sel_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ((sel[i] == '0) && !restart) |=> $stable(counts[i]));
    end

    for (genvar f = 0; f < 2; f++) begin : g_f
        // R11: fixed step of zero or one (modulo)
        p_fstep_r11: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (CNT_W'(counts[NUM_PROG+f] - $past(counts[NUM_PROG+f])) <= CNT_W'(1)));
        // R4: rollover from all ones to zero
        p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((&counts[NUM_PROG+f]) && count_en && fix_strobe[f]) |=> (counts[NUM_PROG+f] == '0));
    end
endmodule

bind dram_perf_counters dpc_checker #(
    .NUM_PROG(NUM_PROG), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .restart(restart),
    .rd_en(reg_rd_en), .addr(reg_addr), .sel(sel), .counts(counts),
    .fix_strobe(fix_strobe), .hi_snap(hi_snap)
);

// File: tb/dram_perf_counters_tb.sv
// Bench for dram_perf_counters with a narrow counter (10 bits, 6-bit low word).
// It keeps expected counts arithmetically and compares them through register reads.
module dram_perf_counters_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int NE = 15;
    localparam int CW = 10;
    localparam int LW = 6;
    localparam int NC = NP + 2;
    localparam int FULL = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt = '0;
    logic          rds = 1'b0, wrs = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0, rdata;

    int checks = 0, fails = 0;
    int exp_cnt [NC];
    int sel_m [NP];
    bit en_m = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_perf_counters #(.NUM_PROG(NP), .NUM_EVT(NE), .CNT_W(CW), .LO_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .rd_strobe_i(rds), .wr_strobe_i(wrs),
        .reg_wr_en(wr_en), .reg_rd_en(rd_en), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output int d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = int'(rdata);
    endtask

    task automatic set_sel(input int i, input int v);
        reg_write(8'h10 + 8'(i), 32'(v)); sel_m[i] = v;
    endtask

    task automatic set_en(input bit e);
        reg_write(8'h00, 32'(e)); en_m = e;
    endtask

    // One cycle of stimulus with the arithmetic model update
    task automatic step(input logic [NE-1:0] e, input bit r, input bit w);
        @(negedge clk); evt = e; rds = r; wrs = w;
        if (en_m) begin
            for (int i = 0; i < NP; i++)
                if (sel_m[i] != 0 && e[sel_m[i]-1] && exp_cnt[i] < FULL) exp_cnt[i]++;
            if (r) exp_cnt[NP]   = (exp_cnt[NP] + 1) & FULL;
            if (w) exp_cnt[NP+1] = (exp_cnt[NP+1] + 1) & FULL;
        end
        @(negedge clk); evt = '0; rds = 1'b0; wrs = 1'b0;
    endtask

    task automatic verify_all(input string req);
        int lo, hi;
        for (int j = 0; j < NC; j++) begin
            reg_read(8'h20 + 8'(j), lo);
            reg_read(8'h01, hi);
            check(req, (hi << LW) | lo, exp_cnt[j]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, lo, hi;
        logic [NE-1:0] pat;
        for (int j = 0; j < NC; j++) exp_cnt[j] = 0;
        for (int i = 0; i < NP; i++) sel_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10, R8: reset state through the register port
        verify_all("R10");
        reg_read(8'h00, v); check("R10 enable", v, 0);
        for (int i = 0; i < NP; i++) begin reg_read(8'h10 + 8'(i), v); check("R10 sel", v, 0); end

        // R1/R8: selector readback, R6: disabled means no counting
        for (int i = 0; i < NP; i++) set_sel(i, i + 1);
        for (int i = 0; i < NP; i++) begin reg_read(8'h10 + 8'(i), v); check("R8 sel readback", v, i + 1); end
        for (int c = 0; c < 5; c++) step('1, 1'b1, 1'b1);
        verify_all("R6 disabled");

        // R1, R3, R11: line k pulsed k+1 times, strobes 3 and 5 times
        set_en(1'b1);
        reg_read(8'h00, v); check("R8 enable readback", v, 1);
        for (int c = 0; c < 8; c++) begin
            pat = '0;
            for (int k = 0; k < 8; k++) if (c < k + 1) pat[k] = 1'b1;
            step(pat, c < 3, c < 5);
        end
        for (int i = 0; i < NP; i++) check("R1 per-line count", exp_cnt[i], i + 1);
        verify_all("R1 R3");

        // R7: restart clears programmable group, fixed counters remain
        reg_write(8'h00, 32'h3);
        for (int i = 0; i < NP; i++) exp_cnt[i] = 0;
        verify_all("R7 restart");

        // R1, R2: reversed selectors, one counter on zero, pattern sweep
        for (int i = 0; i < NP - 1; i++) set_sel(i, 15 - i);
        set_sel(NP - 1, 0);
        for (int c = 0; c < 40; c++) step(NE'(c * 1103 + 7 * c * c), c[0], c[1]);
        check("R2 sel zero holds", exp_cnt[NP-1], 0);
        verify_all("R1 R2 sweep");

        // R7: event in the restart cycle is discarded
        @(negedge clk); wr_en = 1'b1; addr = 8'h00; wdata = 32'h3; evt = '1;
        @(negedge clk); wr_en = 1'b0; evt = '0;
        for (int i = 0; i < NP; i++) exp_cnt[i] = 0;
        verify_all("R7 same-cycle event");

        // R5: saturation at full scale on counter 0
        set_sel(0, 1);
        for (int c = 0; c < FULL + 80; c++) step(NE'(1), 1'b0, 1'b0);
        check("R5 model full", exp_cnt[0], FULL);
        verify_all("R5 saturate");

        // R4: fixed read counter rolls over
        v = exp_cnt[NP];
        for (int c = 0; c < FULL + 7; c++) step('0, 1'b1, 1'b0);
        check("R4 model wrap", exp_cnt[NP], (v + FULL + 7) & FULL);
        verify_all("R4 wrap");

        // R9: snapshot belongs to the low-word read instant
        reg_write(8'h00, 32'h3);
        for (int i = 0; i < NP; i++) exp_cnt[i] = 0;
        set_sel(1, 2);
        for (int c = 0; c < 70; c++) step(NE'(2), 1'b0, 1'b0);
        reg_read(8'h21, lo); check("R9 low word", lo, 70 & 63);
        for (int c = 0; c < 70; c++) step(NE'(2), 1'b0, 1'b0);
        reg_read(8'h01, hi); check("R9 stale snapshot", hi, 70 >> LW);
        reg_read(8'h00, v);  reg_read(8'h01, hi); check("R9 non-counter read keeps snapshot", hi, 70 >> LW);
        reg_read(8'h21, lo); reg_read(8'h01, hi);
        check("R9 fresh pair", (hi << LW) | lo, 140);

        // R6: disable again and confirm counts are held
        set_en(1'b0);
        for (int c = 0; c < 6; c++) step('1, 1'b1, 1'b1);
        verify_all("R6 hold");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule